// File: doc/BRIEF.md
# Codec Response Ring Writer

This block accepts responses from audio codecs and stores each one as an eight-byte entry in a ring buffer held in system memory. A response arrives on a valid/ready handshake as a 32-bit payload, a flag marking it unsolicited, and the 4-bit address of the codec that sent it. For every accepted response the block moves its 8-bit write index forward by one, with wrap, and computes the entry address from a 64-bit ring base. It then issues two 32-bit writes on a simple memory port: the payload first, then a tag word. When both writes have finished, it publishes the new index.

A failed memory write is treated as a ring overrun. The entry is abandoned without a retry, but the index still advances. A sticky overrun flag records the event and raises an interrupt when the interrupt enable is set. Software loads the base halves, clears the index and clears the flag through single-cycle strobe ports.

Top module: `resp_ring_writer`

## Requirements
- R1: During synchronous reset and in the first cycle after it, `wr_ptr` is 0, `ovr_sts` is 0, `irq` is 0, `mem_req` is 0 and `rsp_ready` is 1.
- R2: Each accepted response uses index `wr_ptr + 1` modulo 256. After index 255 the next entry uses index 0.
- R3: The entry byte address is the full 64-bit sum of {`base_hi`, `base_lo`} and 8 times the entry index. The first word goes to that address and the second word to that address plus 4.
- R4: Exactly two writes are issued per response, in order: the payload at offset 0, then the tag word at offset 4.
- R5: Bits 3:0 of the tag word hold the codec address and bit 4 holds the unsolicited flag (1 = unsolicited). All other bits are 0.
- R6: `rsp_ready` is 0 from the cycle after acceptance until the second write completes. While `mem_req` is high and `mem_done` is low, `mem_req`, `mem_addr` and `mem_data` hold their values.
- R7: `wr_ptr` takes the new index in the cycle after the second write completes. This happens even when a write failed, and the failed entry is not retried.
- R8: When either write of an entry returns `mem_err` = 1, `ovr_sts` is 1 from the cycle after the entry completes.
- R9: `irq` is 1 exactly when `ovr_sts` and the overrun interrupt enable are both 1.
- R10: A `sts_clr` pulse clears `ovr_sts` in the next cycle. If an erroring entry completes in the same cycle, `ovr_sts` stays 1.
- R11: A `wp_clr` pulse while idle sets `wr_ptr` to 0, so the next entry lands at index 1.
- R12: `ie_we` loads `ie_wdata` into the interrupt enable. Clearing the enable or the status drops `irq` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsp_valid | input | 1 | Response offered |
| rsp_ready | output | 1 | Block can take a response |
| rsp_data | input | 32 | Response payload |
| rsp_unsol | input | 1 | 1 = unsolicited response |
| rsp_cad | input | 4 | Address of responding codec |
| mem_req | output | 1 | Memory write request, held until done |
| mem_addr | output | 64 | Write byte address |
| mem_data | output | 32 | Write data, little-endian word |
| mem_done | input | 1 | Current write finished this cycle |
| mem_err | input | 1 | Finished write failed (valid with mem_done) |
| base_lo_we | input | 1 | Load lower base half from base_wdata |
| base_hi_we | input | 1 | Load upper base half from base_wdata |
| base_wdata | input | 32 | Base register write data |
| wp_clr | input | 1 | Clear write index to 0 |
| sts_clr | input | 1 | Write-one-to-clear strobe for overrun flag |
| ie_we | input | 1 | Load overrun interrupt enable |
| ie_wdata | input | 1 | Enable value to load |
| wr_ptr | output | 8 | Index of the last completed entry |
| ovr_sts | output | 1 | Sticky overrun flag |
| irq | output | 1 | Overrun interrupt |

## Verification
Two functions can fall in the same cycle: software clearing the overrun flag, and hardware setting it when an entry with a failed write completes. The bench provokes this with zero-latency memory. It then knows the exact commit edge, which is the second edge after acceptance, and pulses `sts_clr` on that edge while the second write is made to fail. The flag must read 1 afterwards. A plain clear with no error pending, checked right after, must then read 0.

// File: rtl/rrw_pkg.sv
package rrw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } rrw_state_e;
endpackage

// File: rtl/rrw_entry_fmt.sv
module rrw_entry_fmt #(
  parameter int DATA_W    = 32,
  parameter int PTR_W     = 8,
  parameter int CAD_W     = 4,
  parameter int UNSOL_BIT = 4
) (
  input  logic [2*DATA_W-1:0] base,
  input  logic [PTR_W-1:0]    idx,
  input  logic                unsol,
  input  logic [CAD_W-1:0]    cad,
  output logic [2*DATA_W-1:0] ent_addr,
  output logic [DATA_W-1:0]   tag_word
);
  localparam int ADDR_W      = 2 * DATA_W;
  localparam int ENTRY_BYTES = 2 * DATA_W / 8;
  localparam int OFS_SHIFT   = $clog2(ENTRY_BYTES);

  always_comb begin
    ent_addr = base + (ADDR_W'(idx) << OFS_SHIFT);
  end

  always_comb begin
    tag_word                 = '0;
    tag_word[CAD_W-1:0]      = cad;
    tag_word[UNSOL_BIT]      = unsol;
  end
endmodule

// File: rtl/rrw_seq.sv
module rrw_seq
  import rrw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PTR_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rsp_valid,
  output logic                rsp_ready,
  input  logic [DATA_W-1:0]   rsp_data,
  input  logic [2*DATA_W-1:0] ent_addr,
  input  logic [DATA_W-1:0]   tag_word,
  output logic [PTR_W-1:0]    nxt_idx,
  output logic                mem_req,
  output logic [2*DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0]   mem_data,
  input  logic                mem_done,
  input  logic                mem_err,
  input  logic                wp_clr,
  output logic [PTR_W-1:0]    wr_ptr,
  output logic                commit_err
);
  localparam int WORD_BYTES = DATA_W / 8;

  rrw_state_e          state;
  logic [DATA_W-1:0]   tag_q;
  logic [PTR_W-1:0]    np_q;
  logic                err_acc;
  logic                commit;

  assign rsp_ready  = (state == ST_IDLE);
  assign nxt_idx    = wr_ptr + PTR_W'(1);
  assign commit     = (state == ST_HI) && mem_done;
  assign commit_err = commit && (err_acc || mem_err);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
      tag_q    <= '0;
      np_q     <= '0;
      err_acc  <= 1'b0;
      wr_ptr   <= '0;
    end else begin
      if (wp_clr)      wr_ptr <= '0;
      else if (commit) wr_ptr <= np_q;
      case (state)
        ST_IDLE: if (rsp_valid) begin
          state    <= ST_LO;
          mem_req  <= 1'b1;
          mem_addr <= ent_addr;
          mem_data <= rsp_data;
          tag_q    <= tag_word;
          np_q     <= nxt_idx;
          err_acc  <= 1'b0;
        end
        ST_LO: if (mem_done) begin
          state    <= ST_HI;
          mem_addr <= mem_addr + (2*DATA_W)'(WORD_BYTES);
          mem_data <= tag_q;
          err_acc  <= mem_err;
        end
        ST_HI: if (mem_done) begin
          state   <= ST_IDLE;
          mem_req <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !rsp_ready); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) && $stable(mem_data))); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (commit && !wp_clr) |=> (wr_ptr == $past(wr_ptr) + PTR_W'(1))); // R2
  AST_PTR_CLR: assert property (@(posedge clk) disable iff (rst)
    wp_clr |=> (wr_ptr == '0)); // R11
endmodule

// File: rtl/rrw_ovr_irq.sv
module rrw_ovr_irq (
  input  logic clk,
  input  logic rst,
  input  logic err_set,
  input  logic sts_clr,
  input  logic ie_we,
  input  logic ie_wdata,
  output logic ovr_sts,
  output logic irq
);
  logic ovr_ie;
  logic sts_n;
  logic ie_n;

  always_comb begin
    sts_n = err_set || (ovr_sts && !sts_clr);
    ie_n  = ie_we ? ie_wdata : ovr_ie;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_sts <= 1'b0;
      ovr_ie  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      ovr_sts <= sts_n;
      ovr_ie  <= ie_n;
      irq     <= sts_n && ie_n;
    end
  end

  AST_ERR_SETS: assert property (@(posedge clk) disable iff (rst)
    err_set |=> ovr_sts); // R8
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (sts_clr && !err_set) |=> !ovr_sts); // R10
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ovr_sts && ovr_ie)); // R9
  AST_IE_OFF: assert property (@(posedge clk) disable iff (rst)
    (ie_we && !ie_wdata) |=> !irq); // R12
endmodule

// File: rtl/resp_ring_writer.sv
module resp_ring_writer #(
  parameter int DATA_W    = 32,
  parameter int PTR_W     = 8,
  parameter int CAD_W     = 4,
  parameter int UNSOL_BIT = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rsp_valid,
  output logic                rsp_ready,
  input  logic [DATA_W-1:0]   rsp_data,
  input  logic                rsp_unsol,
  input  logic [CAD_W-1:0]    rsp_cad,
  output logic                mem_req,
  output logic [2*DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0]   mem_data,
  input  logic                mem_done,
  input  logic                mem_err,
  input  logic                base_lo_we,
  input  logic                base_hi_we,
  input  logic [DATA_W-1:0]   base_wdata,
  input  logic                wp_clr,
  input  logic                sts_clr,
  input  logic                ie_we,
  input  logic                ie_wdata,
  output logic [PTR_W-1:0]    wr_ptr,
  output logic                ovr_sts,
  output logic                irq
);
  localparam int ADDR_W = 2 * DATA_W;

  logic [DATA_W-1:0] base_lo;
  logic [DATA_W-1:0] base_hi;
  logic [ADDR_W-1:0] ent_addr;
  logic [DATA_W-1:0] tag_word;
  logic [PTR_W-1:0]  nxt_idx;
  logic              commit_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_lo <= '0;
      base_hi <= '0;
    end else begin
      if (base_lo_we) base_lo <= base_wdata;
      if (base_hi_we) base_hi <= base_wdata;
    end
  end

  rrw_entry_fmt #(.DATA_W(DATA_W), .PTR_W(PTR_W), .CAD_W(CAD_W), .UNSOL_BIT(UNSOL_BIT)) u_fmt (
    .base     ({base_hi, base_lo}),
    .idx      (nxt_idx),
    .unsol    (rsp_unsol),
    .cad      (rsp_cad),
    .ent_addr (ent_addr),
    .tag_word (tag_word)
  );

  rrw_seq #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_data   (rsp_data),
    .ent_addr   (ent_addr),
    .tag_word   (tag_word),
    .nxt_idx    (nxt_idx),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_data   (mem_data),
    .mem_done   (mem_done),
    .mem_err    (mem_err),
    .wp_clr     (wp_clr),
    .wr_ptr     (wr_ptr),
    .commit_err (commit_err)
  );

  rrw_ovr_irq u_ovr (
    .clk      (clk),
    .rst      (rst),
    .err_set  (commit_err),
    .sts_clr  (sts_clr),
    .ie_we    (ie_we),
    .ie_wdata (ie_wdata),
    .ovr_sts  (ovr_sts),
    .irq      (irq)
  );
endmodule

// File: tb/sim_resp_ring_writer.sv
module sim_resp_ring_writer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rsp_valid = 1'b0;
  logic        rsp_ready;
  logic [31:0] rsp_data = '0;
  logic        rsp_unsol = 1'b0;
  logic [3:0]  rsp_cad = '0;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic [31:0] mem_data;
  logic        mem_done = 1'b0;
  logic        mem_err = 1'b0;
  logic        base_lo_we = 1'b0, base_hi_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        wp_clr = 1'b0, sts_clr = 1'b0, ie_we = 1'b0, ie_wdata = 1'b0;
  logic [7:0]  wr_ptr;
  logic        ovr_sts, irq;

  always #5 clk = ~clk;

  resp_ring_writer u0 (.*);

  int n_chk = 0, n_fail = 0;
  int lat = 0, lat_cnt = 0, wr_cnt = 0, err_at = -1;
  logic [63:0] q_addr[$];
  logic [31:0] q_data[$];
  logic [63:0] base = '0;
  logic [7:0]  exp_ptr = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    mem_done <= 1'b0;
    mem_err  <= 1'b0;
    if (!rst && mem_req) begin
      if (lat_cnt >= lat) begin
        lat_cnt = 0;
        if (q_addr.size() == 0) begin
          chk(1'b0, "R4 unexpected write", mem_addr, 64'h0);
        end else begin
          logic [63:0] ea;
          logic [31:0] ed;
          ea = q_addr.pop_front();
          ed = q_data.pop_front();
          chk(mem_addr == ea, "R3 write address", mem_addr, ea);
          chk(mem_data == ed, "R4/R5 write data", {32'h0, mem_data}, {32'h0, ed});
        end
        mem_done <= 1'b1;
        mem_err  <= (wr_cnt == err_at);
        wr_cnt++;
      end else begin
        lat_cnt++;
      end
    end
  end

  task automatic reg_pulse(input int which, input logic [31:0] d);
    @(negedge clk);
    base_wdata = d;
    ie_wdata   = d[0];
    base_lo_we = (which == 0);
    base_hi_we = (which == 1);
    ie_we      = (which == 2);
    wp_clr     = (which == 3);
    sts_clr    = (which == 4);
    @(negedge clk);
    base_lo_we = 0; base_hi_we = 0; ie_we = 0; wp_clr = 0; sts_clr = 0;
  endtask

  // driver: pushes expected writes, then offers the response
  task automatic send(input logic [31:0] d, input logic u, input logic [3:0] c, input int clr_at);
    logic [63:0] a;
    int n;
    exp_ptr = exp_ptr + 8'd1;
    a = base + {53'h0, exp_ptr, 3'b000};
    q_addr.push_back(a);      q_data.push_back(d);
    q_addr.push_back(a + 4);  q_data.push_back({27'h0, u, c});
    @(negedge clk);
    while (!rsp_ready) @(negedge clk);
    rsp_valid = 1; rsp_data = d; rsp_unsol = u; rsp_cad = c;
    @(posedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      rsp_valid = 0;
      sts_clr = (n == clr_at);
      if (n == 1) chk(rsp_ready == 1'b0, "R6 ready low while busy", {63'h0, rsp_ready}, 64'h0);
    end while (!rsp_ready);
    sts_clr = 0;
    chk(wr_ptr == exp_ptr, "R7 pointer after entry", {56'h0, wr_ptr}, {56'h0, exp_ptr});
    chk(q_addr.size() == 0, "R4 both writes issued", q_addr.size(), 0);
  endtask

  initial begin
    #(200000 * 10);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(wr_ptr == 0 && ovr_sts == 0 && irq == 0 && mem_req == 0, "R1 reset state in reset",
        {wr_ptr, ovr_sts, irq, mem_req}, 0);
    rst = 0;
    @(negedge clk);
    chk(wr_ptr == 0 && ovr_sts == 0 && irq == 0 && mem_req == 0 && rsp_ready == 1, "R1 after reset",
        {wr_ptr, ovr_sts, irq, mem_req, rsp_ready}, 1);

    reg_pulse(0, 32'hFFFF_FC00);
    reg_pulse(1, 32'h0000_0002);
    base = 64'h0000_0002_FFFF_FC00;

    // R2 R3 R4 R5: mixed patterns, two latencies
    send(32'hDEAD_BEEF, 0, 4'h3, -1);
    send(32'h1234_5678, 1, 4'hF, -1);
    lat = 2;
    send(32'h0000_0000, 1, 4'h0, -1);
    send(32'hFFFF_FFFF, 0, 4'hA, -1);
    lat = 0;

    // R2: run across the wrap point (carry into upper base half as well)
    for (int i = 0; i < 258; i++) send(32'hA500_0000 + i, i[0], i[3:0], -1);
    chk(wr_ptr == 8'd6, "R2 pointer wrapped", {56'h0, wr_ptr}, 64'd6);

    // R8 R9: error on second write, interrupt disabled
    err_at = wr_cnt + 1;
    send(32'h0BAD_0001, 0, 4'h1, -1);
    chk(ovr_sts == 1, "R8 status after error", {63'h0, ovr_sts}, 1);
    chk(irq == 0, "R9 irq masked", {63'h0, irq}, 0);

    // R12: enable raises irq; R10 clear drops it
    reg_pulse(2, 32'h1);
    chk(irq == 1, "R12 irq on enable", {63'h0, irq}, 1);
    reg_pulse(4, 32'h1);
    chk(ovr_sts == 0 && irq == 0, "R10 clear status", {ovr_sts, irq}, 0);

    // R7 R8: error on first write, still two writes and pointer advances
    err_at = wr_cnt;
    send(32'h0BAD_0002, 1, 4'h2, -1);
    chk(ovr_sts == 1 && irq == 1, "R8/R9 first-write error", {ovr_sts, irq}, 3);

    // R10: clear in the commit cycle of a failing entry; set wins
    err_at = wr_cnt + 1;
    send(32'h0BAD_0003, 0, 4'h5, 2);
    chk(ovr_sts == 1, "R10 set beats clear", {63'h0, ovr_sts}, 1);
    reg_pulse(4, 32'h1);
    chk(ovr_sts == 0, "R10 plain clear", {63'h0, ovr_sts}, 0);
    err_at = -1;

    // R12: disabling drops irq
    err_at = wr_cnt;
    send(32'h0BAD_0004, 0, 4'h6, -1);
    err_at = -1;
    reg_pulse(2, 32'h0);
    chk(irq == 0 && ovr_sts == 1, "R12 irq off when disabled", {ovr_sts, irq}, 2);

    // R11: pointer clear, next entry at index 1
    reg_pulse(3, 32'h0);
    chk(wr_ptr == 0, "R11 pointer cleared", {56'h0, wr_ptr}, 0);
    exp_ptr = 0;
    send(32'hC0DE_0011, 1, 4'h7, -1);
    chk(wr_ptr == 1, "R11 first entry index 1", {56'h0, wr_ptr}, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule